// File: doc/BRIEF.md
# Interrupt Acknowledge and Activation Path

This block serves one processor of a multi-processor interrupt controller. When the processor strobes an acknowledge, the block takes the interrupt that the selection logic currently presents for that processor, together with its priority, its group and its trigger model. It then either hands the ID back or returns the spurious value 1023. Accepted IDs are marked active. The processor's running priority moves to the interrupt's group priority, and one bit is recorded at the interrupt's preemption level in an active-priority bank. Two such banks exist, one for group 0 and one for group 1. The block also emits a request to clear the pending state.

Software-generated interrupts are IDs 0 to 15. The block keeps an 8-bit map for each of them, with one bit per originating processor. Each acknowledge serves only the lowest-numbered source and reports it in the upper bits of the returned word. The pending clear for such an ID goes out only when its last source has been served.

The result is registered. The acknowledge word and all state updates appear one clock after the strobe, and `ack_valid` pulses in that same cycle. Selection of the pending ID and end-of-interrupt handling belong to neighbouring blocks.

Top module: `ack_activate`

## Requirements
- R1: After reset, `ack_valid` and `clr_valid` are 0 and `ack_word` is 0. The running priority is 0x100, which means idle. Every active bit, every active-priority bit and every source map is 0.
- R2: `ack_valid` is 1 in exactly the cycle after a cycle with `ack_req` high, and 0 otherwise.
- R3: An acknowledge returns 1023, with no change to the running priority, the active bits, the banks or the source maps and with no pending clear, in any of these cases: the priority is greater than or equal to the running priority, or the ID is NUM_IRQ or above (1023 included), or the ID is below 16 and its source map is empty.
- R4: For an accepted ID below 16, the source chosen is the lowest set bit of its map, and that bit alone is cleared. The word is the ID in bits 9:0 and the 3-bit source number in bits 12:10.
- R5: For an accepted ID below 16, a pending clear is issued only if the map becomes empty through this acknowledge.
- R6: For an accepted ID of 16 or above, the word is the ID with bits 12:10 zero, and a pending clear for that ID is always issued.
- R7: The processor mask of a pending clear is all ones when `pend_shared` (the 1-of-N model) is set. Otherwise it is one-hot at CPU_IDX.
- R8: The group priority is the priority ANDed with all-ones shifted left by (binary point + 1). A binary point of 7 gives group priority 0.
- R9: If `groups_en` is 1, `common_bp` is 0 and the ID is group 1, the binary point used is `bin_point_alias` minus one, modulo 8. In every other case it is `bin_point`.
- R10: An accepted ID sets the bit numbered (group priority >> 1) in the flat active-priority vector. That bit lies in register level/32 at position level%32. The group-1 bank is used when `groups_en` and `pend_group` are both 1, and the group-0 bank otherwise. Bits already set stay set.
- R11: An accepted ID sets the running priority to its group priority and sets its bit in `active_vec`.
- R12: A `sgi_set` strobe ORs `sgi_set_bits` into the source map of `sgi_set_id` at the next edge. Map n occupies bits 8n+7:8n of `sgi_src_map`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ack_req | input | 1 | Acknowledge strobe from the processor |
| pend_id | input | 10 | Current pending ID for this processor (1023 = none) |
| pend_prio | input | 8 | Priority of the pending ID (lower is more urgent) |
| pend_group | input | 1 | Group of the pending ID (1 = group 1) |
| pend_shared | input | 1 | Pending ID uses the 1-of-N model |
| groups_en | input | 1 | Interrupt grouping enabled |
| common_bp | input | 1 | Use the main binary point for both groups |
| bin_point | input | 3 | Main binary point |
| bin_point_alias | input | 3 | Aliased binary point for group 1 |
| sgi_set | input | 1 | Strobe to add sources to a software-interrupt map |
| sgi_set_id | input | 4 | Software interrupt whose map is extended |
| sgi_set_bits | input | 8 | Source bits to add |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_word | output | 13 | Returned word: source in 12:10, ID in 9:0 |
| clr_valid | output | 1 | Pending-clear request |
| clr_id | output | 10 | ID whose pending state is cleared |
| clr_cpu_mask | output | 4 | Processors whose pending bit is cleared |
| run_prio | output | 9 | Running priority (0x100 = idle) |
| active_vec | output | 64 | Active bit per ID |
| apr_grp0 | output | 128 | Group-0 active-priority registers, flattened |
| apr_grp1 | output | 128 | Group-1 active-priority registers, flattened |
| sgi_src_map | output | 128 | Source maps of the 16 software interrupts |

## Verification
The main acknowledge path is driven through a table of single acknowledges, each taken from reset. Together they cover every binary-point source: the main value, the aliased value with its wrap at zero, and the common-point override. They also cover both banks, both clear-mask models, the levels at the ends of the range and in between, and both kinds of ID. A wrong shift, bank choice or level index therefore lands on a bit that the table does not expect. Directed sequences separate the priority comparison at equality from the comparison at one below. They also show that the spurious cases leave every piece of state untouched. A two-source software interrupt shows that the first acknowledge serves the lower source without a clear and the second one issues it. Two set strobes in a row show that sources accumulate.

// File: rtl/ack_pkg.sv
// Shared constants for the acknowledge path.
// Assumes IDs are 10 bits wide and the value 1023 is reserved as "none".
package ack_pkg;
    localparam int ID_W        = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
    localparam int PRIO_W      = 8;
    localparam int APR_REG_W   = 32;
endpackage

// File: rtl/ack_prio_calc.sv
// Group-priority and preemption-level calculation.
// Picks the effective binary point (main or aliased minus one), masks the
// priority with it and derives the preemption level as the group priority
// without its lowest bit. Purely combinational.
module ack_prio_calc #(
    parameter int PRIO_W = 8,
    parameter int BP_W   = 3,
    localparam int LVL_W = PRIO_W - 1,
    localparam int SH_W  = BP_W + 1
) (
    input  logic [PRIO_W-1:0] prio,
    input  logic              group1,
    input  logic              groups_en,
    input  logic              common_bp,
    input  logic [BP_W-1:0]   bin_point,
    input  logic [BP_W-1:0]   bin_point_alias,
    output logic [PRIO_W-1:0] grp_prio,
    output logic [LVL_W-1:0]  level
);
    logic [BP_W-1:0]   bp_eff;
    logic [SH_W-1:0]   shamt;
    logic [PRIO_W-1:0] keep_mask;

    // Select the binary point and build the priority mask.
    always_comb begin
        if (groups_en && !common_bp && group1) begin
            bp_eff = bin_point_alias - BP_W'(1);
        end else begin
            bp_eff = bin_point;
        end
        shamt     = {1'b0, bp_eff} + SH_W'(1);
        keep_mask = {PRIO_W{1'b1}} << shamt;
        grp_prio  = prio & keep_mask;
        level     = grp_prio[PRIO_W-1:1];
    end
endmodule

// File: rtl/ack_sgi_src.sv
// Source maps for the software-generated interrupts.
// Holds one map per software ID, with one bit per originating processor.
// A set strobe ORs bits in; a take strobe clears the lowest set bit of the
// addressed map. Both may hit the same map in one cycle. Assumes take_id is
// valid whenever take_en is high.
module ack_sgi_src #(
    parameter int NUM_SGI    = 16,
    parameter int SRC_W      = 8,
    localparam int SEL_W     = $clog2(NUM_SGI),
    localparam int SRC_IDX_W = $clog2(SRC_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en,
    input  logic [SEL_W-1:0]         set_id,
    input  logic [SRC_W-1:0]         set_bits,
    input  logic                     take_en,
    input  logic [SEL_W-1:0]         take_id,
    output logic [SRC_IDX_W-1:0]     sel_src,
    output logic                     sel_nonempty,
    output logic                     sel_last,
    output logic [NUM_SGI*SRC_W-1:0] map_flat
);
    logic [NUM_SGI-1:0][SRC_W-1:0] map_q;
    logic [SRC_W-1:0]              sel_bits;
    logic [SRC_W-1:0]              take_mask;

    // Look up the addressed map and find its lowest set source.
    always_comb begin
        sel_bits = map_q[take_id];
        sel_src  = '0;
        for (int b = SRC_W - 1; b >= 0; b--) begin
            if (sel_bits[b]) sel_src = SRC_IDX_W'(b);
        end
        sel_nonempty = |sel_bits;
        sel_last     = sel_nonempty && ((sel_bits & (sel_bits - SRC_W'(1))) == '0);
        take_mask    = SRC_W'(1) << sel_src;
    end

    // Update every map: drop the served source, merge new sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            for (int g = 0; g < NUM_SGI; g++) begin
                map_q[g] <= (map_q[g] & ~((take_en && take_id == SEL_W'(g)) ? take_mask : '0))
                          | ((set_en && set_id == SEL_W'(g)) ? set_bits : '0);
            end
        end
    end

    // Flatten the maps for observation.
    for (genvar g = 0; g < NUM_SGI; g++) begin : g_flat
        assign map_flat[g*SRC_W +: SRC_W] = map_q[g];
    end

    // R4: with no concurrent set, a take removes exactly one source bit.
    a_r4_take_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (take_en && !set_en) |=> ($countones(map_flat) == $past($countones(map_flat)) - 1));
endmodule

// File: rtl/ack_apr_bank.sv
// One bank of active-priority registers.
// A set strobe marks the bit at the given preemption level, in register
// level/32 at position level%32. Bits are only cleared by reset, because
// priority drop is handled elsewhere.
module ack_apr_bank #(
    parameter int LVL_W    = 7,
    parameter int REG_W    = 32,
    localparam int NUM_REG = (1 << LVL_W) / REG_W,
    localparam int BIT_W   = $clog2(REG_W),
    localparam int RIDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en,
    input  logic [LVL_W-1:0]         level,
    output logic [NUM_REG*REG_W-1:0] apr_flat
);
    logic [RIDX_W-1:0] reg_idx;
    logic [BIT_W-1:0]  bit_idx;

    // Split the level into register index and bit position.
    always_comb begin
        reg_idx = RIDX_W'(level >> BIT_W);
        bit_idx = level[BIT_W-1:0];
    end

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        logic [REG_W-1:0] apr_q;
        // Set the level bit in this register when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                apr_q <= '0;
            end else if (set_en && reg_idx == RIDX_W'(r)) begin
                apr_q[bit_idx] <= 1'b1;
            end
        end
        assign apr_flat[r*REG_W +: REG_W] = apr_q;
    end

    // R10: bits already recorded are never lost.
    a_r10_apr_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((apr_flat & $past(apr_flat)) == $past(apr_flat)));
endmodule

// File: rtl/ack_activate.sv
// Per-processor interrupt acknowledge and activation.
// On ack_req it checks the presented ID against the running priority and
// the source map, then registers the returned word. On acceptance it sets
// the active bit, moves the running priority, marks the preemption level
// in the bank of the ID's group and requests a pending clear. Assumes the
// pending inputs are stable in the strobe cycle.
module ack_activate
    import ack_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    parameter int CPU_IDX = 1,
    parameter int NUM_SGI = 16,
    parameter int SRC_W   = 8,
    localparam int SEL_W     = $clog2(NUM_SGI),
    localparam int SRC_IDX_W = $clog2(SRC_W),
    localparam int WORD_W    = ID_W + SRC_IDX_W,
    localparam int LVL_W     = PRIO_W - 1,
    localparam int APR_W     = 1 << LVL_W,
    localparam int RUN_W     = PRIO_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ack_req,
    input  logic [ID_W-1:0]          pend_id,
    input  logic [PRIO_W-1:0]        pend_prio,
    input  logic                     pend_group,
    input  logic                     pend_shared,
    input  logic                     groups_en,
    input  logic                     common_bp,
    input  logic [2:0]               bin_point,
    input  logic [2:0]               bin_point_alias,
    input  logic                     sgi_set,
    input  logic [SEL_W-1:0]         sgi_set_id,
    input  logic [SRC_W-1:0]         sgi_set_bits,
    output logic                     ack_valid,
    output logic [WORD_W-1:0]        ack_word,
    output logic                     clr_valid,
    output logic [ID_W-1:0]          clr_id,
    output logic [NUM_CPU-1:0]       clr_cpu_mask,
    output logic [RUN_W-1:0]         run_prio,
    output logic [NUM_IRQ-1:0]       active_vec,
    output logic [APR_W-1:0]         apr_grp0,
    output logic [APR_W-1:0]         apr_grp1,
    output logic [NUM_SGI*SRC_W-1:0] sgi_src_map
);
    localparam logic [ID_W-1:0]  IRQ_LIMIT = ID_W'(NUM_IRQ);
    localparam logic [ID_W-1:0]  SGI_LIMIT = ID_W'(NUM_SGI);
    localparam logic [RUN_W-1:0] RUN_IDLE  = RUN_W'(1) << PRIO_W;

    logic [PRIO_W-1:0]    grp_prio;
    logic [LVL_W-1:0]     level;
    logic [SRC_IDX_W-1:0] sel_src;
    logic                 sel_nonempty;
    logic                 sel_last;
    logic                 is_sgi;
    logic                 accept;
    logic                 take_src;
    logic                 use_grp1;
    logic [WORD_W-1:0]    word_next;
    logic                 clr_next;
    logic [RUN_W-1:0]     run_q;
    logic [NUM_IRQ-1:0]   active_q;

    ack_prio_calc #(.PRIO_W(PRIO_W), .BP_W(3)) u_prio (
        .prio            (pend_prio),
        .group1          (pend_group),
        .groups_en       (groups_en),
        .common_bp       (common_bp),
        .bin_point       (bin_point),
        .bin_point_alias (bin_point_alias),
        .grp_prio        (grp_prio),
        .level           (level)
    );

    ack_sgi_src #(.NUM_SGI(NUM_SGI), .SRC_W(SRC_W)) u_sgi (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_en       (sgi_set),
        .set_id       (sgi_set_id),
        .set_bits     (sgi_set_bits),
        .take_en      (take_src),
        .take_id      (pend_id[SEL_W-1:0]),
        .sel_src      (sel_src),
        .sel_nonempty (sel_nonempty),
        .sel_last     (sel_last),
        .map_flat     (sgi_src_map)
    );

    // Decide acceptance and form the returned word and clear request.
    always_comb begin
        is_sgi    = pend_id < SGI_LIMIT;
        accept    = (pend_id < IRQ_LIMIT)
                 && ({1'b0, pend_prio} < run_q)
                 && (!is_sgi || sel_nonempty);
        take_src  = ack_req && accept && is_sgi;
        use_grp1  = groups_en && pend_group;
        if (!accept) begin
            word_next = WORD_W'(SPURIOUS_ID);
        end else if (is_sgi) begin
            word_next = {sel_src, pend_id};
        end else begin
            word_next = {{SRC_IDX_W{1'b0}}, pend_id};
        end
        clr_next = accept && (!is_sgi || sel_last);
    end

    ack_apr_bank #(.LVL_W(LVL_W), .REG_W(APR_REG_W)) u_apr_g0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (ack_req && accept && !use_grp1),
        .level    (level),
        .apr_flat (apr_grp0)
    );

    ack_apr_bank #(.LVL_W(LVL_W), .REG_W(APR_REG_W)) u_apr_g1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (ack_req && accept && use_grp1),
        .level    (level),
        .apr_flat (apr_grp1)
    );

    // Register the acknowledge result and the pending-clear request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid    <= 1'b0;
            ack_word     <= '0;
            clr_valid    <= 1'b0;
            clr_id       <= '0;
            clr_cpu_mask <= '0;
        end else begin
            ack_valid <= ack_req;
            clr_valid <= ack_req && clr_next;
            if (ack_req) begin
                ack_word     <= word_next;
                clr_id       <= pend_id;
                clr_cpu_mask <= pend_shared ? {NUM_CPU{1'b1}} : (NUM_CPU'(1) << CPU_IDX);
            end
        end
    end

    // Move the running priority on an accepted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= RUN_IDLE;
        end else if (ack_req && accept) begin
            run_q <= {1'b0, grp_prio};
        end
    end

    // Mark the accepted ID active.
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_active
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active_q[i] <= 1'b0;
            end else if (ack_req && accept && pend_id == ID_W'(i)) begin
                active_q[i] <= 1'b1;
            end
        end
    end

    assign run_prio   = run_q;
    assign active_vec = active_q;

    // R2: the valid pulse follows the strobe by one cycle.
    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid);
    a_r2_no_valid_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> !ack_valid);

    // R3: a spurious result leaves the running priority and pending alone.
    a_r3_spurious_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_word == WORD_W'(SPURIOUS_ID)) |-> ($stable(run_q) && !clr_valid));

    // R11: an accepted acknowledge always lowers the running priority.
    a_r11_run_prio_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_word != WORD_W'(SPURIOUS_ID)) |-> (run_q < $past(run_q)));

    // R7: a clear names this processor alone or every processor.
    a_r7_clear_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> ($onehot(clr_cpu_mask) || (&clr_cpu_mask)));

    // R10: an acknowledge adds at most one bit across both banks.
    a_r10_one_bank_bit: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($countones(apr_grp0 ^ $past(apr_grp0))
                 + $countones(apr_grp1 ^ $past(apr_grp1))) <= 1));
endmodule

// File: tb/test_ack_activate.sv
// Self-checking bench: table of single acknowledges from reset, then
// directed sequences for reset, spurious cases and multi-source interrupts.
module test_ack_activate;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ack_req = 1'b0;
    logic [9:0]   pend_id = '0;
    logic [7:0]   pend_prio = '0;
    logic         pend_group = 1'b0;
    logic         pend_shared = 1'b0;
    logic         groups_en = 1'b0;
    logic         common_bp = 1'b0;
    logic [2:0]   bin_point = '0;
    logic [2:0]   bin_point_alias = '0;
    logic         sgi_set = 1'b0;
    logic [3:0]   sgi_set_id = '0;
    logic [7:0]   sgi_set_bits = '0;
    logic         ack_valid;
    logic [12:0]  ack_word;
    logic         clr_valid;
    logic [9:0]   clr_id;
    logic [3:0]   clr_cpu_mask;
    logic [8:0]   run_prio;
    logic [63:0]  active_vec;
    logic [127:0] apr_grp0;
    logic [127:0] apr_grp1;
    logic [127:0] sgi_src_map;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ack_activate i_ack_activate (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .pend_id(pend_id),
        .pend_prio(pend_prio), .pend_group(pend_group), .pend_shared(pend_shared),
        .groups_en(groups_en), .common_bp(common_bp), .bin_point(bin_point),
        .bin_point_alias(bin_point_alias), .sgi_set(sgi_set), .sgi_set_id(sgi_set_id),
        .sgi_set_bits(sgi_set_bits), .ack_valid(ack_valid), .ack_word(ack_word),
        .clr_valid(clr_valid), .clr_id(clr_id), .clr_cpu_mask(clr_cpu_mask),
        .run_prio(run_prio), .active_vec(active_vec), .apr_grp0(apr_grp0),
        .apr_grp1(apr_grp1), .sgi_src_map(sgi_src_map)
    );

    typedef struct packed {
        logic [9:0]  id;
        logic [7:0]  prio;
        logic        grp;
        logic        shared;
        logic        gen;
        logic        cbp;
        logic [2:0]  bp;
        logic [2:0]  abp;
        logic [7:0]  pre;
        logic [7:0]  left;
        logic [12:0] word;
        logic [8:0]  run;
        logic [6:0]  lvl;
        logic        ns;
        logic        clr;
        logic [3:0]  mask;
    } vec_t;

    // Hand-computed expectations from the requirements (R4 to R11).
    localparam vec_t TBL [8] = '{
        '{10'd40, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 8'h00, 13'd40,   9'h044, 7'd34, 1'b0, 1'b1, 4'b0010},
        '{10'd41, 8'h7F, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2, 3'd3, 8'h00, 8'h00, 13'd41,   9'h078, 7'd60, 1'b1, 1'b1, 4'b1111},
        '{10'd42, 8'hC5, 1'b1, 1'b0, 1'b1, 1'b1, 3'd3, 3'd0, 8'h00, 8'h00, 13'd42,   9'h0C0, 7'd96, 1'b1, 1'b1, 4'b0010},
        '{10'd20, 8'h3B, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 3'd5, 8'h00, 8'h00, 13'd20,   9'h038, 7'd28, 1'b0, 1'b1, 4'b0010},
        '{10'd5,  8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'h28, 8'h20, 13'd3077, 9'h020, 7'd16, 1'b0, 1'b0, 4'b0000},
        '{10'd15, 8'h10, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd1, 8'h80, 8'h00, 13'd7183, 9'h010, 7'd8,  1'b1, 1'b1, 4'b0010},
        '{10'd63, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 3'd0, 8'h00, 8'h00, 13'd63,   9'h000, 7'd0,  1'b0, 1'b1, 4'b0010},
        '{10'd33, 8'h9A, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 8'h00, 13'd33,   9'h000, 7'd0,  1'b1, 1'b1, 4'b0010}
    };

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ack_req = 1'b0;
        sgi_set = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic add_src(input logic [3:0] id, input logic [7:0] bits);
        @(negedge clk);
        sgi_set = 1'b1;
        sgi_set_id = id;
        sgi_set_bits = bits;
        @(negedge clk);
        sgi_set = 1'b0;
    endtask

    // Strobe one acknowledge; returns at the negedge after the result edge.
    task automatic do_ack(input logic [9:0] id, input logic [7:0] prio, input logic grp,
                          input logic shared, input logic gen, input logic cbp,
                          input logic [2:0] bp, input logic [2:0] abp);
        @(negedge clk);
        pend_id = id;
        pend_prio = prio;
        pend_group = grp;
        pend_shared = shared;
        groups_en = gen;
        common_bp = cbp;
        bin_point = bp;
        bin_point_alias = abp;
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [127:0] g0_snap;
        // R1: reset state.
        do_reset();
        @(negedge clk);
        chk("R1", "ack_valid", 128'(ack_valid), 128'd0);
        chk("R1", "clr_valid", 128'(clr_valid), 128'd0);
        chk("R1", "ack_word", 128'(ack_word), 128'd0);
        chk("R1", "run_prio", 128'(run_prio), 128'h100);
        chk("R1", "active", 128'(active_vec), 128'd0);
        chk("R1", "apr banks", apr_grp0 | apr_grp1, 128'd0);
        chk("R1", "source maps", sgi_src_map, 128'd0);

        // Table walk: one acknowledge per vector from reset (R4-R11).
        foreach (TBL[k]) begin
            vec_t v;
            v = TBL[k];
            do_reset();
            if (v.pre != 8'h00) add_src(v.id[3:0], v.pre);
            do_ack(v.id, v.prio, v.grp, v.shared, v.gen, v.cbp, v.bp, v.abp);
            chk("R2", $sformatf("vec%0d valid", k), 128'(ack_valid), 128'd1);
            chk(v.id < 16 ? "R4" : "R6", $sformatf("vec%0d word", k), 128'(ack_word), 128'(v.word));
            chk("R8_R9_R11", $sformatf("vec%0d run_prio", k), 128'(run_prio), 128'(v.run));
            chk("R11", $sformatf("vec%0d active", k), 128'(active_vec), 128'(64'(1) << v.id));
            chk("R10", $sformatf("vec%0d grp1 bank", k), apr_grp1,
                v.ns ? (128'(1) << v.lvl) : 128'd0);
            chk("R10", $sformatf("vec%0d grp0 bank", k), apr_grp0,
                v.ns ? 128'd0 : (128'(1) << v.lvl));
            chk("R5_R6", $sformatf("vec%0d clr_valid", k), 128'(clr_valid), 128'(v.clr));
            if (v.clr) begin
                chk("R7", $sformatf("vec%0d clr mask", k), 128'(clr_cpu_mask), 128'(v.mask));
                chk("R6", $sformatf("vec%0d clr id", k), 128'(clr_id), 128'(v.id));
            end
            if (v.id < 16)
                chk("R4", $sformatf("vec%0d remaining map", k),
                    128'(sgi_src_map[v.id*8 +: 8]), 128'(v.left));
            @(negedge clk);
            chk("R2", $sformatf("vec%0d valid drops", k), 128'(ack_valid), 128'd0);
        end

        // R3: priority equal to the running priority is refused; one below is taken.
        do_reset();
        do_ack(10'd40, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        g0_snap = apr_grp0;
        do_ack(10'd50, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        chk("R3", "equal prio word", 128'(ack_word), 128'd1023);
        chk("R3", "equal prio run", 128'(run_prio), 128'h044);
        chk("R3", "equal prio clr", 128'(clr_valid), 128'd0);
        chk("R3", "equal prio bank", apr_grp0, g0_snap);
        chk("R3", "equal prio active", 128'(active_vec), 128'(64'(1) << 40));
        do_ack(10'd50, 8'h43, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        chk("R3", "one below word", 128'(ack_word), 128'd50);
        chk("R8", "one below run", 128'(run_prio), 128'h042);
        // R3: no pending ID, out-of-range ID, empty software map.
        do_ack(10'd1023, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        chk("R3", "none word", 128'(ack_word), 128'd1023);
        do_ack(10'd64, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        chk("R3", "out of range word", 128'(ack_word), 128'd1023);
        do_ack(10'd3, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        chk("R3", "empty map word", 128'(ack_word), 128'd1023);
        chk("R3", "empty map run", 128'(run_prio), 128'h042);
        chk("R3", "empty map clr", 128'(clr_valid), 128'd0);

        // R5: two sources; the clear comes with the second acknowledge only.
        do_reset();
        add_src(4'd2, 8'h06);
        do_ack(10'd2, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        chk("R4", "first source word", 128'(ack_word), 128'd1026);
        chk("R5", "no clear while sources left", 128'(clr_valid), 128'd0);
        chk("R4", "map after first", 128'(sgi_src_map[23:16]), 128'h04);
        do_ack(10'd2, 8'h60, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
        chk("R4", "second source word", 128'(ack_word), 128'd2050);
        chk("R5", "clear on last source", 128'(clr_valid), 128'd1);
        chk("R5", "clear id", 128'(clr_id), 128'd2);
        chk("R5", "map empty", 128'(sgi_src_map[23:16]), 128'h00);

        // R12: set strobes accumulate sources.
        do_reset();
        add_src(4'd9, 8'h01);
        add_src(4'd9, 8'h04);
        chk("R12", "merged map", 128'(sgi_src_map[79:72]), 128'h05);
        chk("R12", "other maps untouched", sgi_src_map & ~(128'hFF << 72), 128'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule